// File: doc/BRIEF.md
# Two-Lane Float/Integer Converter

This block converts a 64-bit word made of two independent 32-bit lanes. Lane 0 is bits 31:0 and lane 1 is bits 63:32. In the default direction each lane holds an IEEE-754 single-precision value. That value becomes a signed 32-bit integer, truncated toward zero and clamped to the integer range. In the other direction each lane holds a signed 32-bit integer, which becomes a single-precision value. Any significant bits beyond the 24-bit significand are dropped, not rounded.

A caller presents an operand, a direction bit and a valid strobe. One clock later the result appears with its own valid strobe. The result register holds its last value while no new operand arrives. Infinities and NaNs map to saturated integer codes, chosen by their sign bit. Denormal inputs count as zero. No exception flags are produced.

Top module: `fp_int_conv`

## Requirements
- R1: The two lanes are converted independently: the result in bits 31:0 depends only on operand bits 31:0, and the result in bits 63:32 depends only on operand bits 63:32.
- R2: With `to_float`=0, a finite single-precision lane whose magnitude lies in [1, 2^31) gives the signed integer nearest to it in the direction of zero, for example 3.7 gives 3 and -3.7 gives -3.
- R3: With `to_float`=0, the lane result is 0 for +0, -0, any denormal (exponent field bits 30:23 equal to 0), and any normal value of magnitude below 1.
- R4: With `to_float`=0, a lane with sign bit 31 clear whose value is at or above 2^31, or which is +infinity or a NaN, gives 32'h7FFF_FFFF.
- R5: With `to_float`=0, a lane with sign bit 31 set whose value is at or below -2^31, or which is -infinity or a NaN, gives 32'h8000_0000.
- R6: With `to_float`=1, a signed integer lane whose magnitude is below 2^24 converts exactly to single precision: sign in bit 31, biased exponent (bias 127) in bits 30:23, fraction in bits 22:0.
- R7: With `to_float`=1, an integer lane whose magnitude needs more than 24 significant bits keeps only its top 24 significant bits, so the magnitude is truncated. For example 32'h7FFF_FFFF gives 32'h4EFF_FFFF and 16777217 gives 32'h4B80_0000.
- R8: With `to_float`=1, an integer 0 gives 32'h0000_0000 (+0.0), and 32'h8000_0000 gives exactly 32'hCF00_0000 (-2^31).
- R9: `out_valid` equals `in_valid` delayed by one clock, and a strobed operand's result is on `out_word` in that same cycle. After reset `out_valid` and `out_word` are 0.
- R10: While `in_valid` is low, `out_word` keeps its previous value, whatever `in_word` and `to_float` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| to_float | input | 1 | Direction: 0 float to integer, 1 integer to float |
| in_word | input | 64 | Two 32-bit operand lanes |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_word | output | 64 | Two 32-bit result lanes |

## Verification
The bench targets the edges of the float-to-integer range. The largest single below 2^31 must give 2147483520. Exactly 2^31 must clamp, while exactly -2^31 must come out as 32'h8000_0000. A wrong exponent threshold shows up here as a wrapped value or a clamp that fires one step too early.

Infinities and NaNs of both signs are applied to check that the saturated code follows the sign bit. Denormals and negative zero are applied as well, where a design that fails to flush them would produce a nonzero result or -1.

In the integer-to-float direction the bench applies 0, -2^31, 2^31-1 and 2^24+1. A design that rounds instead of truncating gives 32'h4F00_0000 for 2^31-1, and a design that negates -2^31 wrongly gives a positive or garbled exponent.

Operands that mix cases across the two lanes expose any coupling between lanes. Idle cycles with changing inputs expose a result register that does not hold.

// File: rtl/fp_int_conv.sv
module fp_int_conv #(
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  to_float,
  input  logic [LANES*32-1:0]   in_word,
  output logic                  out_valid,
  output logic [LANES*32-1:0]   out_word
);
  localparam int LW = 32;
  localparam logic [7:0]  BIAS    = 8'd127;
  localparam logic [7:0]  SAT_EXP = 8'd158;
  localparam logic [LW-1:0] INT_MAX = 32'h7FFF_FFFF;
  localparam logic [LW-1:0] INT_MIN = 32'h8000_0000;

  logic [LANES*LW-1:0] nxt;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] a;
    assign a = in_word[g*LW +: LW];

    logic          fs;
    logic [7:0]    fe;
    logic [7:0]    up;
    logic [LW-1:0] sig;
    logic [LW-1:0] fmag;
    logic [LW-1:0] f2i;
    assign fs   = a[31];
    assign fe   = a[30:23];
    assign up   = fe - BIAS;
    assign sig  = {8'd0, 1'b1, a[22:0]};
    assign fmag = (up >= 8'd23) ? (sig << (up - 8'd23)) : (sig >> (8'd23 - up));
    assign f2i  = (fe >= SAT_EXP) ? (fs ? INT_MIN : INT_MAX) :
                  (fe < BIAS)     ? '0 :
                  (fs ? -fmag : fmag);

    logic          ineg;
    logic [LW-1:0] imag;
    logic [4:0]    lead;
    logic [LW-1:0] norm;
    logic [LW-1:0] i2f;
    assign ineg = a[31];
    assign imag = ineg ? -a : a;
    always_comb begin
      lead = '0;
      for (int k = 0; k < LW; k++)
        if (imag[k]) lead = k[4:0];
    end
    assign norm = imag << (5'd31 - lead);
    assign i2f  = (a == '0) ? '0 : {ineg, {3'd0, lead} + BIAS, norm[30:8]};

    assign nxt[g*LW +: LW] = to_float ? i2f : f2i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= nxt;
    end
  end
endmodule

module fp_int_conv_chk #(
  parameter int LANES = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                to_float,
  input logic [LANES*32-1:0] in_word,
  input logic                out_valid,
  input logic [LANES*32-1:0] out_word
);
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));
  p_sat_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !to_float && !in_word[31] && in_word[30:23] == 8'hFF)
    |=> out_word[31:0] == 32'h7FFF_FFFF);
  p_sat_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !to_float && in_word[31] && in_word[30:23] == 8'hFF)
    |=> out_word[31:0] == 32'h8000_0000);
  p_tiny_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !to_float && in_word[30:23] < 8'd127)
    |=> out_word[31:0] == 32'h0);
  p_zero_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && to_float && in_word[31:0] == 32'h0)
    |=> out_word[31:0] == 32'h0);
endmodule

bind fp_int_conv fp_int_conv_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/test_fp_int_conv.sv
`timescale 1ns/1ps
module test_fp_int_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        to_float = 1'b0;
  logic [63:0] in_word = '0;
  logic        out_valid;
  logic [63:0] out_word;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fp_int_conv #(.LANES(2)) i_fp_int_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .to_float(to_float),
    .in_word(in_word), .out_valid(out_valid), .out_word(out_word));

  function automatic logic [31:0] ref_f2i(input logic [31:0] b);
    longint m;
    int e;
    e = int'(b[30:23]);
    if (e >= 158) return b[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    if (e < 127) return 32'h0;
    m = longint'({1'b1, b[22:0]});
    if (e >= 150) m = m << (e - 150);
    else m = m >> (150 - e);
    if (b[31]) m = -m;
    return m[31:0];
  endfunction

  function automatic logic [31:0] ref_i2f(input logic [31:0] v);
    longint m;
    int p;
    logic [7:0] ex;
    if (v == 0) return 32'h0;
    m = v[31] ? -longint'($signed(v)) : longint'(v);
    p = 0;
    while ((m >> (p + 1)) != 0) p++;
    m = (p >= 23) ? (m >> (p - 23)) : (m << (23 - p));
    ex = 8'(127 + p);
    return {v[31], ex, m[22:0]};
  endfunction

  function automatic logic [63:0] ref_conv(input logic [63:0] w, input logic dir);
    return dir ? {ref_i2f(w[63:32]), ref_i2f(w[31:0])}
               : {ref_f2i(w[63:32]), ref_f2i(w[31:0])};
  endfunction

  logic        m_valid = 1'b0;
  logic [63:0] m_word = '0;
  string       m_tag = "R9";
  string       cur_tag = "R10";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_word  <= '0;
      m_tag   <= "R9";
    end else begin
      m_valid <= in_valid;
      if (in_valid) begin
        m_word <= ref_conv(in_word, to_float);
        m_tag  <= cur_tag;
      end else begin
        m_tag  <= "R10";
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R9 valid", {63'd0, out_valid}, {63'd0, m_valid});
      check(m_tag, out_word, m_word);
    end
  end

  task automatic drive(input logic [63:0] w, input logic dir, input string tag);
    @(negedge clk);
    in_word  = w;
    to_float = dir;
    in_valid = 1'b1;
    cur_tag  = tag;
  endtask

  task automatic idle(input logic [63:0] w, input logic dir);
    @(negedge clk);
    in_word  = w;
    to_float = dir;
    in_valid = 1'b0;
    cur_tag  = "R10";
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [63:0] x;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset word", out_word, 64'd0);
    rst_n = 1'b1;

    drive({32'hC06CCCCD, 32'h406CCCCD}, 1'b0, "R2 +-3.7");
    drive({32'h3F800000, 32'h4EFFFFFF}, 1'b0, "R2 one and top");
    drive({32'h47F12065, 32'hCB800001}, 1'b0, "R2 mid");
    drive({32'h80000000, 32'h3F000000}, 1'b0, "R3 -0 and 0.5");
    drive({32'h00000001, 32'h807FFFFF}, 1'b0, "R3 denormals");
    drive({32'h7F800000, 32'h4F000000}, 1'b0, "R4 inf and 2^31");
    drive({32'h7FC00000, 32'h7F7FFFFF}, 1'b0, "R4 NaN and max");
    drive({32'hFF800000, 32'hCF000000}, 1'b0, "R5 -inf and -2^31");
    drive({32'hFFC00000, 32'hCF000001}, 1'b0, "R5 -NaN and below");
    drive({32'h7F800000, 32'h3F000000}, 1'b0, "R1 mixed lanes");
    drive({32'hFFFFFFFF, 32'h00000001}, 1'b1, "R6 +-1");
    drive({32'h00FFFFFF, 32'hFF000001}, 1'b1, "R6 24-bit");
    drive({32'h7FFFFFFF, 32'h01000001}, 1'b1, "R7 truncate");
    drive({32'hFEFFFFFF, 32'h12345678}, 1'b1, "R7 negative");
    drive({32'h80000000, 32'h00000000}, 1'b1, "R8 zero and min");
    drive({32'h00000000, 32'h7FFFFFFF}, 1'b1, "R1 mixed lanes");
    idle(64'hDEADBEEF_01234567, 1'b1);
    idle(64'h7F800000_FF800000, 1'b0);
    drive(64'h4F000000_00000005, 1'b0, "R9 back to back");
    drive(64'h4F000000_00000005, 1'b1, "R9 back to back");
    idle(64'h0, 1'b0);

    x = 64'h1234_5678_9ABC_DEF1;
    for (int i = 0; i < 200; i++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      if (i % 5 == 4) idle(x, x[0]);
      else drive(x, x[1], x[1] ? "R6 R7 sweep" : "R2 R3 R4 R5 sweep");
    end
    idle(64'h0, 1'b0);
    idle(64'h0, 1'b0);

    // explicit spot values at the ports
    drive({32'h00000000, 32'h80000000}, 1'b1, "R8 spot");
    idle(64'h0, 1'b0);
    @(posedge clk); #1;
    check("R8 min to -2^31", {32'd0, out_word[31:0]}, {32'd0, 32'hCF000000});
    drive({32'h7FFFFFFF, 32'h7FFFFFFF}, 1'b1, "R7 spot");
    idle(64'h0, 1'b0);
    @(posedge clk); #1;
    check("R7 2^31-1 truncated", {32'd0, out_word[31:0]}, {32'd0, 32'h4EFFFFFF});
    drive({32'h4EFFFFFF, 32'hC06CCCCD}, 1'b0, "R2 spot");
    idle(64'h0, 1'b0);
    @(posedge clk); #1;
    check("R2 spot", out_word, {32'h7FFFFF80, 32'hFFFFFFFD});
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule